// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frame bytes from a byte stream that marks the first and last byte of each frame. It places them in memory buffers of 128 bytes each. A ring of two-word descriptors in memory describes the buffers. The first word of a descriptor holds the buffer address and two control bits: an ownership bit and an end-of-ring bit. The second word receives a status word that the block writes.

Before it writes a buffer, the block reads the first word of the next descriptor. It uses a buffer only if software has handed it over. A frame longer than one buffer continues into the following descriptors. After the last descriptor in the ring, the block goes back to the ring base address. For each buffer the block writes the data words first, then the status word, then the first word with the ownership bit set.

If a frame needs another buffer and the next descriptor is still held by software, the block discards the rest of that frame and gives a one-cycle error pulse. The results of address filtering come in on sideband pins. The block only copies them into the status word of the buffer that holds the end of the frame.

Top module: `rxr_ring_writer`

## Requirements
- R1: While reset is held, the block keeps `rx_ready_o`, `mem_wr_en_o` and `rsrc_err_o` low and requests a read of the descriptor at `ring_base_i`. After reset, the first descriptor fetched is the one at the ring base.
- R2: Frame bytes are packed little-endian into 32-bit words. The byte at buffer offset 4w+k goes to bits 8k+7:8k of word w. Word w is written at buffer address + 4w, where the buffer address is descriptor word 0 with bits 1:0 cleared. Byte lanes past the last frame byte of the final word are written as zero.
- R3: Each buffer holds 128 bytes. Byte 128·j+i of a frame goes to byte offset i of the j-th buffer used by that frame. A new frame always starts a new buffer.
- R4: Descriptors sit 8 bytes apart, starting at `ring_base_i`. After the block uses a descriptor whose word 0 has bit 1 set, the next descriptor it fetches is the one at `ring_base_i`.
- R5: If bit 0 (ownership) of the fetched descriptor word 0 is 1 and no frame is in progress, the block keeps `rx_ready_o` low. It writes nothing and raises no error until software clears that bit.
- R6: Status word bit 14 is 1 in the buffer that holds the first byte of a frame. Bit 15 is 1 in the buffer that holds the last byte. Bits 11:0 hold the frame length in bytes in the last buffer and are 0 in every other buffer.
- R7: In the last buffer of a frame, status bit 31 copies `flt_bcast_i`. Bits 26, 25, 24 and 23 copy `flt_addr_i[0]`, `[1]`, `[2]` and `[3]`. Bit 22 copies `flt_type_i`. All of these are sampled with the last byte and are 0 in every other buffer.
- R8: For each buffer, the block writes the data words first. Next it writes the status word at descriptor + 4. Last it writes descriptor word 0 as the buffer address with bit 1 unchanged and bit 0 set.
- R9: If a frame needs another buffer and the next descriptor still has bit 0 set, `rsrc_err_o` pulses for exactly one cycle. The rest of the frame, up to its last byte, is accepted and discarded without any memory write. The buffers already filled for that frame keep their written status.
- R10: Bytes that arrive while no frame is open and whose start marker is 0 are accepted and discarded. They cause no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base_i | input | AW | Byte address of the first descriptor |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| rx_ready_o | output | 1 | Byte accepted on a clock edge where valid and ready are both high |
| flt_bcast_i | input | 1 | Broadcast flag for the current frame |
| flt_addr_i | input | 4 | Match flags of address comparators 1 to 4 (bit 0 = comparator 1) |
| flt_type_i | input | 1 | Type-ID match flag |
| mem_rd_en_o | output | 1 | Descriptor read request |
| mem_rd_addr_o | output | AW | Descriptor read byte address |
| mem_rd_data_i | input | 32 | Read data, valid the cycle after the request |
| mem_wr_en_o | output | 1 | Word write strobe |
| mem_wr_addr_o | output | AW | Word write byte address |
| mem_wr_data_o | output | 32 | Word write data |
| rsrc_err_o | output | 1 | One-cycle pulse when a frame loses its buffer |

## Verification
A wrong descriptor pointer shows up within a few cycles of the end of a frame. Descriptor word 0 is marked at an unexpected address, or the next read after a ring-ending descriptor does not return to the base. A wrong byte counter or packing state shows up as soon as the frame's data is written: either a word is misplaced or padded wrongly, or the length field and end flag are wrong in that buffer's status word. A wrong frame-open state shows up only when the next descriptor is still held by software. Then either the error pulse is missing or spurious, or frame bytes that should be dropped are written to memory.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 12;
  localparam int NUM_ADDR  = 4;
  localparam int OWN_BIT   = 0;
  localparam int WRAP_BIT  = 1;
  localparam int SOF_BIT   = 14;
  localparam int EOF_BIT   = 15;
  localparam int TYPE_BIT  = 22;
  localparam int ADDR1_BIT = 26;
  localparam int BCAST_BIT = 31;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_CHECK,
    ST_FILL,
    ST_STAT,
    ST_MARK,
    ST_DROP
  } wr_state_e;

  typedef struct packed {
    logic                bcast;
    logic [NUM_ADDR-1:0] amatch;
    logic                tmatch;
  } flt_t;
endpackage

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt
  import rxr_pkg::*;
(
  input  logic [LEN_W-1:0]  len_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  flt_t              flt_i,
  output logic [WORD_W-1:0] status_o
);
  always_comb begin
    status_o          = '0;
    status_o[SOF_BIT] = sof_i;
    status_o[EOF_BIT] = eof_i;
    if (eof_i) begin
      status_o[LEN_W-1:0] = len_i;
      status_o[BCAST_BIT] = flt_i.bcast;
      status_o[TYPE_BIT]  = flt_i.tmatch;
      for (int k = 0; k < NUM_ADDR; k++) begin
        status_o[ADDR1_BIT-k] = flt_i.amatch[k];
      end
    end
  end
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer #(
  parameter int BUF_BYTES = 128,
  localparam int CW = $clog2(BUF_BYTES),
  localparam int IW = CW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic [7:0]    byte_i,
  input  logic          last_i,
  output logic          flush_o,
  output logic [31:0]   word_o,
  output logic [IW-1:0] widx_o,
  output logic          full_o
);
  logic [CW-1:0] cnt;
  logic [31:0]   acc;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign word_o[8*g +: 8] = (cnt[1:0] == 2'(g)) ? byte_i : acc[8*g +: 8];
  end

  assign flush_o = vld_i && ((cnt[1:0] == 2'd3) || last_i);
  assign full_o  = vld_i && (cnt == CW'(BUF_BYTES - 1));
  assign widx_o  = cnt[CW-1:2];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt <= '0;
      acc <= '0;
    end else if (vld_i) begin
      cnt <= cnt + 1'b1;
      acc <= flush_o ? '0 : word_o;
    end
  end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] desc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      desc_o <= base_i;
    end else if (adv_i) begin
      desc_o <= wrap_i ? base_i : desc_o + AW'(DESC_BYTES);
    end
  end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ring_base_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  output logic              rx_ready_o,
  input  logic              flt_bcast_i,
  input  logic [3:0]        flt_addr_i,
  input  logic              flt_type_i,
  output logic              mem_rd_en_o,
  output logic [AW-1:0]     mem_rd_addr_o,
  input  logic [WORD_W-1:0] mem_rd_data_i,
  output logic              mem_wr_en_o,
  output logic [AW-1:0]     mem_wr_addr_o,
  output logic [WORD_W-1:0] mem_wr_data_o,
  output logic              rsrc_err_o
);
  localparam int CW         = $clog2(BUF_BYTES);
  localparam int IW         = CW - 2;
  localparam int DESC_BYTES = 8;
  localparam int STAT_OFS   = 4;

  wr_state_e         state;
  logic              in_frame;
  logic [AW-1:0]     buf_addr;
  logic              wrap_q;
  logic              has_sof;
  logic              buf_eof;
  logic [LEN_W-1:0]  frame_len;
  flt_t              flt_q;
  logic              err_q;
  logic              wr_en_q;
  logic [AW-1:0]     wr_addr_q;
  logic [WORD_W-1:0] wr_data_q;

  logic [AW-1:0]     desc_addr;
  logic              own_seen;
  logic              open_buf;
  logic              fbyte;
  logic              pk_flush;
  logic              pk_full;
  logic [31:0]       pk_word;
  logic [IW-1:0]     pk_widx;
  logic [WORD_W-1:0] status_w;

  assign own_seen   = mem_rd_data_i[OWN_BIT];
  assign open_buf   = (state == ST_CHECK) && !own_seen;
  assign rx_ready_o = (state == ST_FILL) || (state == ST_DROP);
  assign fbyte      = (state == ST_FILL) && rx_valid_i && (in_frame || rx_sof_i);

  rxr_ring_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) ptr_i (
    .clk    (clk),
    .rst    (rst),
    .base_i (ring_base_i),
    .adv_i  (state == ST_MARK),
    .wrap_i (wrap_q),
    .desc_o (desc_addr)
  );

  rxr_packer #(.BUF_BYTES(BUF_BYTES)) pack_i (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (open_buf),
    .vld_i   (fbyte),
    .byte_i  (rx_data_i),
    .last_i  (rx_eof_i),
    .flush_o (pk_flush),
    .word_o  (pk_word),
    .widx_o  (pk_widx),
    .full_o  (pk_full)
  );

  rxr_status_fmt fmt_i (
    .len_i    (frame_len),
    .sof_i    (has_sof),
    .eof_i    (buf_eof),
    .flt_i    (flt_q),
    .status_o (status_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FETCH;
      in_frame  <= 1'b0;
      buf_addr  <= '0;
      wrap_q    <= 1'b0;
      has_sof   <= 1'b0;
      buf_eof   <= 1'b0;
      frame_len <= '0;
      flt_q     <= '0;
      err_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      err_q   <= 1'b0;
      wr_en_q <= 1'b0;
      case (state)
        ST_FETCH: state <= ST_CHECK;
        ST_CHECK: begin
          buf_addr <= {mem_rd_data_i[AW-1:2], 2'b00};
          wrap_q   <= mem_rd_data_i[WRAP_BIT];
          if (!own_seen) begin
            has_sof <= 1'b0;
            buf_eof <= 1'b0;
            state   <= ST_FILL;
          end else if (in_frame) begin
            err_q    <= 1'b1;
            in_frame <= 1'b0;
            state    <= ST_DROP;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_FILL: begin
          if (fbyte) begin
            in_frame  <= !rx_eof_i;
            frame_len <= rx_sof_i ? LEN_W'(1) : frame_len + 1'b1;
            if (rx_sof_i) has_sof <= 1'b1;
            if (pk_flush) begin
              wr_en_q   <= 1'b1;
              wr_addr_q <= buf_addr + AW'({pk_widx, 2'b00});
              wr_data_q <= pk_word;
            end
            if (rx_eof_i) begin
              buf_eof      <= 1'b1;
              flt_q.bcast  <= flt_bcast_i;
              flt_q.amatch <= flt_addr_i;
              flt_q.tmatch <= flt_type_i;
            end
            if (rx_eof_i || pk_full) state <= ST_STAT;
          end
        end
        ST_STAT: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= desc_addr + AW'(STAT_OFS);
          wr_data_q <= status_w;
          state     <= ST_MARK;
        end
        ST_MARK: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= desc_addr;
          wr_data_q <= WORD_W'({buf_addr[AW-1:2], wrap_q, 1'b1});
          state     <= ST_FETCH;
        end
        ST_DROP: begin
          if (rx_valid_i && rx_eof_i) state <= ST_FETCH;
        end
        default: state <= ST_FETCH;
      endcase
    end
  end

  assign mem_rd_en_o   = (state == ST_FETCH);
  assign mem_rd_addr_o = desc_addr;
  assign mem_wr_en_o   = wr_en_q;
  assign mem_wr_addr_o = wr_addr_q;
  assign mem_wr_data_o = wr_data_q;
  assign rsrc_err_o    = err_q;
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_ready_o,
  input logic          rsrc_err_o,
  input logic          mem_rd_en_o,
  input logic [AW-1:0] mem_rd_addr_o,
  input logic          rd_own_i,
  input logic          mem_wr_en_o,
  input logic [AW-1:0] mem_wr_addr_o,
  input logic          mark_bit_i
);
  logic [AW-1:0] desc_l;
  logic          desc_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_l <= '0;
      desc_v <= 1'b0;
    end else if (mem_rd_en_o) begin
      desc_l <= mem_rd_addr_o;
      desc_v <= 1'b1;
    end
  end

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsrc_err_o |=> !rsrc_err_o);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsrc_err_o |-> ($past(rd_own_i) && $past(mem_rd_en_o, 2)));

  // R2
  wr_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en_o |-> (mem_wr_addr_o[1:0] == 2'b00));

  // R5
  fetch_stall_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en_o |-> !rx_ready_o);

  // R8
  mark_order_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_v && mem_wr_en_o && (mem_wr_addr_o == desc_l)) |->
      ($past(mem_wr_en_o) && ($past(mem_wr_addr_o) == desc_l + AW'(4)) && mark_bit_i));
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.AW(AW)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .rx_ready_o    (rx_ready_o),
  .rsrc_err_o    (rsrc_err_o),
  .mem_rd_en_o   (mem_rd_en_o),
  .mem_rd_addr_o (mem_rd_addr_o),
  .rd_own_i      (mem_rd_data_i[0]),
  .mem_wr_en_o   (mem_wr_en_o),
  .mem_wr_addr_o (mem_wr_addr_o),
  .mark_bit_i    (mem_wr_data_o[0])
);

// File: tb/rxr_ring_writer_tb_top.sv
module rxr_ring_writer_tb_top;
  localparam int AW      = 32;
  localparam int BASE    = 32'h100;
  localparam int BUFBASE = 32'h400;
  localparam int ND      = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic [AW-1:0] ring_base;
  logic          rx_valid, rx_sof, rx_eof, rx_ready;
  logic [7:0]    rx_data;
  logic          f_bcast, f_type;
  logic [3:0]    f_addr;
  logic          rd_en, wr_en, err;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0]   rd_data, wr_data;

  logic [31:0] mem [0:1023];
  logic        sw_we;
  logic [9:0]  sw_idx;
  logic [31:0] sw_data;

  int n_chk  = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int err_cnt = 0;
  bit finished = 0;

  rxr_ring_writer #(.AW(AW), .BUF_BYTES(128)) dut_i (
    .clk (clk), .rst (rst), .ring_base_i (ring_base),
    .rx_valid_i (rx_valid), .rx_data_i (rx_data), .rx_sof_i (rx_sof),
    .rx_eof_i (rx_eof), .rx_ready_o (rx_ready),
    .flt_bcast_i (f_bcast), .flt_addr_i (f_addr), .flt_type_i (f_type),
    .mem_rd_en_o (rd_en), .mem_rd_addr_o (rd_addr), .mem_rd_data_i (rd_data),
    .mem_wr_en_o (wr_en), .mem_wr_addr_o (wr_addr), .mem_wr_data_o (wr_data),
    .rsrc_err_o (err)
  );

  always @(posedge clk) begin
    if (sw_we) mem[sw_idx] <= sw_data;
    else if (wr_en) mem[wr_addr[11:2]] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr[11:2]];
    if (!rst && wr_en) wr_cnt <= wr_cnt + 1;
    if (!rst && err) err_cnt <= err_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_idx = 10'(idx); sw_data = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int n, input int i);
    return 8'((n * 37 + i * 5 + 1) & 255);
  endfunction

  function automatic logic [31:0] flt_bits(input int n);
    logic [31:0] v = '0;
    v[31] = n[0];
    v[22] = n[1];
    for (int k = 0; k < 4; k++) v[26-k] = ((n * 3) >> k) & 1;
    return v;
  endfunction

  function automatic logic [31:0] desc_w0(input int idx);
    return 32'(BUFBASE + 128 * idx) | ((idx == ND - 1) ? 32'h2 : 32'h0);
  endfunction

  task automatic send(input int len, input int n, input bit marks);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_data  = pat(n, i);
      rx_sof   = marks && (i == 0);
      rx_eof   = marks && (i == len - 1);
      f_bcast  = n[0];
      f_type   = n[1];
      f_addr   = 4'((n * 3) & 15);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic verify_buf(input int idx, input int n, input int len, input int j, input bit last);
    int di = (BASE >> 2) + 2 * idx;
    int bw = (BUFBASE >> 2) + 32 * idx;
    logic [31:0] e0 = desc_w0(idx) | 32'h1;
    logic [31:0] es;
    int nbytes = last ? len - 128 * j : 128;
    chk(mem[di] == e0, "R4 R8 descriptor word0", mem[di], e0);
    es = (j == 0) ? 32'h4000 : 32'h0;
    if (last) es = es | 32'h8000 | 32'(len);
    chk(mem[di+1][21:0] == es[21:0], "R6 status flags/length", mem[di+1], es);
    es = last ? flt_bits(n) : 32'h0;
    chk(mem[di+1][31:22] == es[31:22], "R7 filter bits", mem[di+1], es);
    for (int w = 0; w < (nbytes + 3) / 4; w++) begin
      logic [31:0] ew = '0;
      for (int k = 0; k < 4; k++) begin
        int i = 128 * j + 4 * w + k;
        if (i < len) ew[8*k +: 8] = pat(n, i);
      end
      chk(mem[bw+w] == ew, (j == 0) ? "R2 data word" : "R3 data word", mem[bw+w], ew);
    end
    sw_write(di, desc_w0(idx));
  endtask

  task automatic verify_frame(input int len, input int n, input int start);
    int nb = (len + 127) / 128;
    for (int j = 0; j < nb; j++) verify_buf((start + j) % ND, n, len, j, j == nb - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int tail = 0;
    int n = 0;
    int wc, ec, hi;
    int lens [16] = '{1, 2, 3, 4, 5, 7, 8, 63, 127, 128, 129, 255, 256, 257, 300, 512};
    rst = 1'b1; ring_base = 32'(BASE);
    rx_valid = 0; rx_data = 0; rx_sof = 0; rx_eof = 0;
    f_bcast = 0; f_addr = 0; f_type = 0; sw_we = 0; sw_idx = 0; sw_data = 0;
    for (int i = 0; i < ND; i++) begin
      sw_write((BASE >> 2) + 2 * i, desc_w0(i));
      sw_write((BASE >> 2) + 2 * i + 1, 32'h0);
    end
    for (int i = 0; i < 128; i++) sw_write((BUFBASE >> 2) + i, 32'hA5A5A5A5);
    @(negedge clk);
    // R1 reset state
    chk(rd_en == 1'b1, "R1 fetch request in reset", 32'(rd_en), 32'h1);
    chk(rd_addr == 32'(BASE), "R1 first fetch at ring base", rd_addr, 32'(BASE));
    chk(rx_ready == 1'b0, "R1 ready low", 32'(rx_ready), 32'h0);
    chk(wr_en == 1'b0 && err == 1'b0, "R1 no write or error", {30'h0, wr_en, err}, 32'h0);
    rst = 1'b0;
    settle();

    // R2 R3 R4 R6 R7 R8: length sweep across the ring
    foreach (lens[q]) begin
      send(lens[q], n, 1'b1);
      settle();
      verify_frame(lens[q], n, tail);
      tail = (tail + (lens[q] + 127) / 128) % ND;
      n++;
    end

    // R10 stray bytes outside a frame
    wc = wr_cnt;
    send(3, n, 1'b0);
    settle();
    chk(wr_cnt == wc, "R10 no write for stray bytes", 32'(wr_cnt), 32'(wc));
    chk(rx_ready == 1'b1, "R10 still waiting for a frame", 32'(rx_ready), 32'h1);
    send(20, n, 1'b1);
    settle();
    verify_frame(20, n, tail);
    tail = (tail + 1) % ND;
    n++;

    // R5 ring full of unreleased buffers
    for (int f = 0; f < ND; f++) begin
      send(9 + 8 * f, n + f, 1'b1);
      settle();
    end
    wc = wr_cnt; ec = err_cnt; hi = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (rx_ready) hi++;
    end
    chk(hi == 0, "R5 ready held low while owned", 32'(hi), 32'h0);
    chk(wr_cnt == wc, "R5 no write while owned", 32'(wr_cnt), 32'(wc));
    chk(err_cnt == ec, "R5 no error between frames", 32'(err_cnt), 32'(ec));
    for (int f = 0; f < ND; f++) verify_frame(9 + 8 * f, n + f, (tail + f) % ND);
    n += ND;

    // R9 next descriptor owned in mid-frame
    sw_write((BASE >> 2) + 2 * ((tail + 1) % ND), desc_w0((tail + 1) % ND) | 32'h1);
    wc = wr_cnt; ec = err_cnt;
    send(200, n, 1'b1);
    settle();
    chk(err_cnt == ec + 1, "R9 one error pulse", 32'(err_cnt), 32'(ec + 1));
    chk(wr_cnt == wc + 34, "R9 dropped bytes not written", 32'(wr_cnt), 32'(wc + 34));
    verify_buf(tail, n, 200, 0, 1'b0);
    sw_write((BASE >> 2) + 2 * ((tail + 1) % ND), desc_w0((tail + 1) % ND));
    tail = (tail + 1) % ND;
    n++;
    settle();
    // R9 recovery after the drop
    send(50, n, 1'b1);
    settle();
    verify_frame(50, n, tail);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule